// File: doc/BRIEF.md
# Instruction Prefix Scanner

This stage sits at the front of an instruction decoder. It receives instruction bytes one per cycle. A start strobe marks the first byte of each instruction, and a mode input selects either 64-bit operation or the older 32/16-bit operation. Every byte is sorted into one of four kinds: a legacy prefix, a REX prefix, the 0x0F escape byte, or the primary opcode. Once the opcode has been consumed, the stage raises a registered summary for one cycle and keeps those values until the next summary. The summary gives the REX bits that take effect, the operand-size override after REX.W has been accounted for, the mandatory-prefix candidate, the opcode byte, and whether the escape byte was present.

A REX byte only counts when it sits directly in front of the opcode or the escape byte. If any later prefix follows it, the REX bits are dropped. The stage also enforces the 15-byte length limit. If a sixteenth byte arrives before the opcode has been found, the stage ends the instruction with a length fault. ModR/M, SIB, displacement and immediate bytes are handled by later stages.

Top module: `insn_prefix_scanner`

## Requirements
- R1: In 64-bit mode (`mode64`=1), a byte 0x40..0x4F is a REX prefix, and its low nibble is reported on `sum_rex` with W=bit 3, R=bit 2, X=bit 1, B=bit 0.
- R2: When `mode64`=0, a byte 0x40..0x4F is taken as the primary opcode and `sum_rex` reads 0.
- R3: REX bits are reported only if the REX byte directly precedes the opcode or the 0x0F byte. If a legacy prefix comes after the REX byte, `sum_rex` is 0.
- R4: When several REX bytes appear back to back, only the last one (the one next to the opcode or escape) is reported.
- R5: The legacy prefixes are 0x26, 0x2E, 0x36, 0x3E, 0x64, 0x65, 0x66, 0x67, 0xF0, 0xF2 and 0xF3. They may appear in any number and any order. `sum_mand` reports the last of 0x66/0xF2/0xF3 that was seen, or 0x00 if none appeared.
- R6: `sum_osz` is 1 when 0x66 was seen, except when REX.W is in effect and 0x66 is not acting as a mandatory prefix. 0x66 acts as a mandatory prefix when the escape byte was seen and `sum_mand` is 0x66.
- R7: When a 0x0F byte appears in a prefix position, `sum_esc` is set. The byte after it is taken as the opcode, whatever its value.
- R8: If an instruction reaches its sixteenth byte without an earlier opcode, the summary is raised on that byte with `sum_lenflt`=1. An instruction of 15 bytes or fewer gives `sum_lenflt`=0.
- R9: `sum_vld` pulses for exactly one cycle, in the cycle after the ending byte is consumed. All summary fields hold their values between pulses.
- R10: While the stage is idle, bytes that arrive without `insn_start` are ignored. A start strobe in the middle of an instruction throws away the partial instruction and begins a new one.
- R11: A synchronous reset (`rst`=1) clears every output to 0 and leaves the stage idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_vld | input | 1 | Byte input is valid this cycle |
| byte_in | input | 8 | Instruction byte |
| insn_start | input | 1 | Current byte is the first byte of an instruction |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = legacy mode |
| sum_vld | output | 1 | One-cycle summary strobe |
| sum_rex | output | 4 | Effective REX {W,R,X,B} |
| sum_osz | output | 1 | Effective operand-size override |
| sum_mand | output | 8 | Mandatory-prefix candidate byte, or 0x00 |
| sum_opc | output | 8 | Primary opcode byte |
| sum_esc | output | 1 | 0x0F escape byte was present |
| sum_lenflt | output | 1 | Instruction exceeded 15 bytes |

## Verification
The bench aims at orderings where a stage that only tracks a single flag would go wrong.

- **REX followed by 0x66.** A design that never clears a stale REX would report W=1 and clear the override.
- **0x66, REX.W, escape.** A design that applies the REX.W cancellation without regard to the mandatory-prefix case would drop the override.
- **REX-valued bytes in legacy mode.** A stage that ignores the mode input would hang waiting for the opcode.
- **Sixteen prefixes.** An off-by-one counter would give a fault at 15 bytes or none at 16.

Random runs mix every prefix class with the escape byte and both modes.

// File: rtl/insn_prefix_scanner.sv
module insn_prefix_scanner #(
  parameter int MAX_LEN = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  input  logic       insn_start,
  input  logic       mode64,
  output logic       sum_vld,
  output logic [3:0] sum_rex,
  output logic       sum_osz,
  output logic [7:0] sum_mand,
  output logic [7:0] sum_opc,
  output logic       sum_esc,
  output logic       sum_lenflt
);

  localparam int CW = $clog2(MAX_LEN + 2);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [3:0]    rex_q;
  logic          s66_q;
  logic [7:0]    mand_q;
  logic          esc_q;

  wire take = byte_vld & (insn_start | busy);

  wire [CW-1:0] cur_cnt  = insn_start ? '0 : cnt;
  wire [3:0]    cur_rex  = insn_start ? 4'h0 : rex_q;
  wire          cur_66   = ~insn_start & s66_q;
  wire [7:0]    cur_mand = insn_start ? 8'h00 : mand_q;
  wire          cur_esc  = ~insn_start & esc_q;

  wire is_seg  = (byte_in == 8'h26) | (byte_in == 8'h2E) | (byte_in == 8'h36) |
                 (byte_in == 8'h3E) | (byte_in == 8'h64) | (byte_in == 8'h65);
  wire is_mpx  = (byte_in == 8'h66) | (byte_in == 8'hF2) | (byte_in == 8'hF3);
  wire is_leg  = is_seg | is_mpx | (byte_in == 8'h67) | (byte_in == 8'hF0);
  wire is_rex  = mode64 & (byte_in[7:4] == 4'h4);
  wire is_escb = (byte_in == 8'h0F);
  wire is_opc  = cur_esc | ~(is_leg | is_rex | is_escb);
  wire over    = (cur_cnt == CW'(MAX_LEN));
  wire done    = take & (is_opc | over);

  wire mand_act = cur_esc & (cur_mand == 8'h66);
  wire osz_eff  = cur_66 & ~(cur_rex[3] & ~mand_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      cnt        <= '0;
      rex_q      <= 4'h0;
      s66_q      <= 1'b0;
      mand_q     <= 8'h00;
      esc_q      <= 1'b0;
      sum_vld    <= 1'b0;
      sum_rex    <= 4'h0;
      sum_osz    <= 1'b0;
      sum_mand   <= 8'h00;
      sum_opc    <= 8'h00;
      sum_esc    <= 1'b0;
      sum_lenflt <= 1'b0;
    end else begin
      sum_vld <= 1'b0;
      if (done) begin
        busy       <= 1'b0;
        sum_vld    <= 1'b1;
        sum_rex    <= cur_rex;
        sum_osz    <= osz_eff;
        sum_mand   <= cur_mand;
        sum_opc    <= byte_in;
        sum_esc    <= cur_esc;
        sum_lenflt <= over;
      end else if (take) begin
        busy   <= 1'b1;
        cnt    <= cur_cnt + 1'b1;
        rex_q  <= is_rex ? byte_in[3:0] : (is_escb ? cur_rex : 4'h0);
        s66_q  <= cur_66 | (byte_in == 8'h66);
        mand_q <= is_mpx ? byte_in : cur_mand;
        esc_q  <= cur_esc | is_escb;
      end
    end
  end

endmodule

// File: rtl/insn_prefix_scanner_chk.sv
module insn_prefix_scanner_chk (
  input logic       clk,
  input logic       rst,
  input logic       byte_vld,
  input logic [7:0] byte_in,
  input logic       insn_start,
  input logic       mode64,
  input logic       sum_vld,
  input logic [3:0] sum_rex,
  input logic       sum_osz,
  input logic [7:0] sum_mand,
  input logic [7:0] sum_opc,
  input logic       sum_esc,
  input logic       sum_lenflt
);

  AST_VLD_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst) sum_vld |-> $past(byte_vld)); // R9
  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (rst)
    !sum_vld |-> $stable({sum_rex, sum_osz, sum_mand, sum_opc, sum_esc, sum_lenflt})); // R9
  AST_LEGACY_4X_OPCODE: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && insn_start && !mode64 && byte_in[7:4] == 4'h4)
    |=> (sum_vld && sum_opc == $past(byte_in) && sum_rex == 4'h0)); // R2
  AST_REX_NOT_OPCODE: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && insn_start && mode64 && byte_in[7:4] == 4'h4) |=> !sum_vld); // R1
  AST_FAULT_WITH_VLD: assert property (@(posedge clk) disable iff (rst) $rose(sum_lenflt) |-> sum_vld); // R8
  AST_MAND_LEGAL: assert property (@(posedge clk) disable iff (rst)
    sum_vld |-> (sum_mand == 8'h00 || sum_mand == 8'h66 || sum_mand == 8'hF2 || sum_mand == 8'hF3)); // R5

endmodule

bind insn_prefix_scanner insn_prefix_scanner_chk u_chk (.*);

// File: tb/insn_prefix_scanner_bench.sv
`timescale 1ns/1ps
module insn_prefix_scanner_bench;

  localparam int MAXL = 15;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       insn_start = 1'b0;
  logic       mode64 = 1'b1;
  logic       sum_vld;
  logic [3:0] sum_rex;
  logic       sum_osz;
  logic [7:0] sum_mand;
  logic [7:0] sum_opc;
  logic       sum_esc;
  logic       sum_lenflt;

  always #2.5 clk = ~clk;

  insn_prefix_scanner #(.MAX_LEN(MAXL)) u_insn_prefix_scanner (.*);

  int total = 0;
  int bad = 0;
  logic [7:0] bq [0:19];
  int blen;
  int e_stop;
  logic [22:0] e_pack;

  wire [22:0] act_pack = {sum_lenflt, sum_esc, sum_osz, sum_mand, sum_rex, sum_opc};

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_pfx(input logic [7:0] b, input bit m64);
    return b == 8'h26 || b == 8'h2E || b == 8'h36 || b == 8'h3E || b == 8'h64 ||
           b == 8'h65 || b == 8'h66 || b == 8'h67 || b == 8'hF0 || b == 8'hF2 ||
           b == 8'hF3 || b == 8'h0F || (m64 && b[7:4] == 4'h4);
  endfunction

  task automatic model(input bit m64);
    logic [3:0] rx = 0;
    logic s66 = 0;
    logic [7:0] md = 0;
    logic es = 0;
    e_stop = -1;
    for (int i = 0; i < blen; i++) begin
      logic [7:0] b = bq[i];
      bit ov = (i == MAXL);
      bit op = es || !is_pfx(b, m64);
      if (op || ov) begin
        e_stop = i;
        e_pack = {ov, es, s66 & ~(rx[3] & ~(es & (md == 8'h66))), md, rx, b};
        return;
      end
      if (b == 8'h0F) es = 1;
      else if (m64 && b[7:4] == 4'h4) rx = b[3:0];
      else begin
        rx = 0;
        if (b == 8'h66) s66 = 1;
        if (b == 8'h66 || b == 8'hF2 || b == 8'hF3) md = b;
      end
    end
  endtask

  task automatic run(input bit m64, input string tag);
    model(m64);
    mode64 = m64;
    for (int i = 0; i <= e_stop; i++) begin
      byte_vld = 1'b1;
      byte_in = bq[i];
      insn_start = (i == 0);
      @(negedge clk);
    end
    byte_vld = 1'b0;
    insn_start = 1'b0;
    check(sum_vld === 1'b1, {tag, " R9 vld"}, 32'(sum_vld), 1);
    check(act_pack === e_pack, tag, 32'(act_pack), 32'(e_pack));
    @(negedge clk);
    check(sum_vld === 1'b0 && act_pack === e_pack, "R9 pulse/hold", 32'({sum_vld, act_pack}), 32'(e_pack));
  endtask

  task automatic set2(input logic [7:0] a, input logic [7:0] b);
    bq[0] = a; bq[1] = b; blen = 2;
  endtask

  task automatic set4(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c, input logic [7:0] d);
    bq[0] = a; bq[1] = b; bq[2] = c; bq[3] = d; blen = 4;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] pool [0:12];
    pool = '{8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65, 8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3, 8'h0F, 8'h48};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(act_pack === 23'd0 && sum_vld === 1'b0, "R11 reset", 32'(act_pack), 0);
    rst = 1'b0;
    @(negedge clk);

    set4(8'h66, 8'h48, 8'h0F, 8'h6E); run(1, "R3 R6 66 48 0F 6E");
    check(sum_rex === 4'h8 && sum_osz === 1'b1, "R6 mandatory 66 kept", 32'({sum_rex, sum_osz}), 32'h11);
    set4(8'h48, 8'h66, 8'h0F, 8'h6E); run(1, "R3 48 66 0F 6E");
    check(sum_rex === 4'h0 && sum_osz === 1'b1, "R3 stale rex dropped", 32'({sum_rex, sum_osz}), 32'h01);
    bq[0] = 8'h48; blen = 1; run(0, "R2 legacy 48");
    check(sum_opc === 8'h48, "R2 legacy opcode", 32'(sum_opc), 32'h48);
    set4(8'h40, 8'h4F, 8'h89, 8'h00); blen = 3; run(1, "R4 40 4F 89");
    check(sum_rex === 4'hF, "R4 last rex", 32'(sum_rex), 32'hF);
    set2(8'h4A, 8'h01); run(1, "R1 rex 4A");
    check(sum_rex === 4'hA, "R1 bit order", 32'(sum_rex), 32'hA);
    bq[0] = 8'h66; bq[1] = 8'h48; bq[2] = 8'h89; blen = 3; run(1, "R6 66 48 89");
    check(sum_osz === 1'b0, "R6 W cancels 66", 32'(sum_osz), 0);
    bq[0] = 8'h66; bq[1] = 8'h40; bq[2] = 8'h89; blen = 3; run(1, "R6 66 40 89");
    bq[0] = 8'hF3; bq[1] = 8'h66; bq[2] = 8'hF2; bq[3] = 8'h0F; bq[4] = 8'h10; blen = 5; run(1, "R5 mand last");
    check(sum_mand === 8'hF2, "R5 F2 reported", 32'(sum_mand), 32'hF2);
    bq[0] = 8'h2E; bq[1] = 8'h3E; bq[2] = 8'h64; bq[3] = 8'h65; bq[4] = 8'h26;
    bq[5] = 8'h36; bq[6] = 8'h67; bq[7] = 8'hF0; bq[8] = 8'h90; blen = 9; run(1, "R5 all segs");
    set2(8'h0F, 8'h66); run(1, "R7 esc then 66");
    check(sum_esc === 1'b1 && sum_opc === 8'h66, "R7 opcode after esc", 32'({sum_esc, sum_opc}), 32'h166);
    for (int i = 0; i < 16; i++) bq[i] = 8'h2E;
    blen = 16; run(1, "R8 16 prefixes");
    check(sum_lenflt === 1'b1, "R8 fault", 32'(sum_lenflt), 1);
    for (int i = 0; i < 14; i++) bq[i] = 8'h3E;
    bq[14] = 8'h90; blen = 15; run(1, "R8 15 bytes");
    check(sum_lenflt === 1'b0, "R8 no fault", 32'(sum_lenflt), 0);

    byte_vld = 1'b1; byte_in = 8'h90; insn_start = 1'b0;
    repeat (3) @(negedge clk);
    byte_vld = 1'b0;
    check(sum_vld === 1'b0 && act_pack === e_pack, "R10 idle ignore", 32'({sum_vld, act_pack}), 32'(e_pack));
    byte_vld = 1'b1; byte_in = 8'h66; insn_start = 1'b1; mode64 = 1'b1;
    @(negedge clk);
    byte_vld = 1'b0; insn_start = 1'b0;
    set4(8'h48, 8'h0F, 8'hAF, 8'h00); blen = 3; run(1, "R10 restart");
    check(sum_osz === 1'b0 && sum_rex === 4'h8, "R10 old 66 dropped", 32'({sum_rex, sum_osz}), 32'h10);

    for (int n = 0; n < 400; n++) begin
      bit m = 1'($urandom % 2);
      int np = $urandom % 17;
      for (int i = 0; i < np; i++) begin
        int k = $urandom % 14;
        bq[i] = (k == 13) ? 8'(8'h40 + ($urandom % 16)) : pool[k];
      end
      do bq[np] = 8'($urandom); while (is_pfx(bq[np], m));
      blen = np + 1;
      run(m, "R1 R3 R5 R6 R7 R8 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule